// File: doc/BRIEF.md
# Block-Write Configuration Slave for a Two-Wire Management Bus

This block is a write-only slave on an SMBus-style two-wire bus. It holds a small bank of 8-bit configuration registers that a bus host fills in with a single block-write transaction. The slave watches the clock and data lines from the system clock domain and accepts the bytes of that transaction. It acknowledges each accepted byte by pulling the data line low, and it loads the data bytes into its registers one after another. The block does not support reads, indexed writes, clock stretching or packet error checking.

The register contents are driven out in parallel. Three controls are decoded from them: a spread-spectrum enable, a spread depth, and an overclock level. The decoder also raises a request to three-state the outputs or enter test mode when one particular combination is written. Anything downstream of the slave sees only these parallel outputs.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset every register reads 0, the data line is released (`sda_pull_o` = 0), `ss_en_o` = 0, `spread_deep_o` = 0, `oclk_lvl_o` = 0 and `tristate_req_o` = 0.
- R2: The first byte after a START is acknowledged only if it equals 0xD2 (7-bit address 0x69 with the write bit 0). Any other value, including 0xD3, is not acknowledged, and the slave then ignores the bus until the next START.
- R3: The second byte must be the command code 0x00. Any other value is not acknowledged, and no register is written.
- R4: The third byte is the byte count. Values 1 to 32 are acknowledged. A count of 0 or a count above 32 is not acknowledged, and no register is written.
- R5: Each byte is shifted in MSB first on rising SCL. Data bytes are written to registers 0, 1, 2 and so on in ascending order, and every data byte up to the count is acknowledged. A transfer may end with a STOP after any whole byte.
- R6: Data bytes that fall within the count but whose index is 6 or more are acknowledged and discarded. Data bytes beyond the count are not acknowledged.
- R7: A STOP or a repeated START that arrives before the eighth bit of a byte aborts that byte, which is not written. Bytes completed before the abort keep their values.
- R8: `ss_en_o` equals bit 3 of register 0.
- R9: Let A = register 5 bit 5 and B = register 5 bit 6. When spread spectrum is on: `spread_deep_o` = B (1 means the deeper spread), and `oclk_lvl_o` is 1 (5%) if A is 1, otherwise 0. When spread spectrum is off: `spread_deep_o` = 0, and `oclk_lvl_o` is 1 (5%) for A=1,B=0, 2 (10%) for A=0,B=1, and 0 otherwise. A level of 2 is therefore possible only with spread spectrum off.
- R10: `tristate_req_o` is 1 exactly when spread spectrum is off and A = B = 1. In that case `oclk_lvl_o` is 0.
- R11: For an accepted byte, `sda_pull_o` goes high after the SCL fall that ends bit 8. It stays high through the SCL high of the ninth clock and is released after the SCL fall that ends that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | When 1, the open-drain driver pulls the data line low (acknowledge) |
| cfg_o | output | 48 | Register bank; register k occupies bits [8k+7:8k] |
| ss_en_o | output | 1 | Spread spectrum enable |
| spread_deep_o | output | 1 | 1 selects the deeper spread |
| oclk_lvl_o | output | 2 | Overclock level: 0 = none, 1 = 5%, 2 = 10% |
| tristate_req_o | output | 1 | Three-state / test mode request |

## Verification
The hardest state to reach from the ports is a byte cut off partway through by a STOP or a repeated START. The bench clocks in a few bits of all-ones and then issues the bus condition directly. It then checks that the register that would have taken the byte still holds zero, while earlier whole bytes have landed. A second hard case is the difference between a discarded byte (index 6 or above, within the count) and a refused byte (beyond the count). Both come from transactions whose sent length exceeds the bank size or the declared count, and the bench checks the acknowledge bit of every byte against a value it computes from the address, command and count.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  typedef enum logic [1:0] {STG_ADDR, STG_CMD, STG_CNT, STG_DATA} stage_e;
  typedef enum logic [1:0] {LNK_IDLE, LNK_RX, LNK_ACK} link_e;
  localparam logic [1:0] OC_NONE = 2'd0;
  localparam logic [1:0] OC_5PCT = 2'd1;
  localparam logic [1:0] OC_10PCT = 2'd2;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s      = scl_p[STAGES-1];
  assign sda_o      = sda_p[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // bus conditions: data edge while clock stays high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter logic [7:0] CMD_CODE = 8'h00,
  parameter int MAX_CNT = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  output logic             ack_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  link_e            state_q;
  stage_e           stage_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shreg_q;
  logic             ack_q;
  logic [IDX_W-1:0] remain_q, idx_q;
  logic             byte_ok, byte_done;

  always_comb begin
    byte_ok = 1'b0;
    unique case (stage_q)
      STG_ADDR: byte_ok = (shreg_q == {SLV_ADDR, 1'b0});
      STG_CMD:  byte_ok = (shreg_q == CMD_CODE);
      STG_CNT:  byte_ok = (shreg_q != 8'd0) && (shreg_q <= 8'(MAX_CNT));
      STG_DATA: byte_ok = (remain_q != '0);
      default:  byte_ok = 1'b0;
    endcase
  end

  assign byte_done = (state_q == LNK_RX) && scl_fall_i && (bit_cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LNK_IDLE;
      stage_q   <= STG_ADDR;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ack_q     <= 1'b0;
      remain_q  <= '0;
      idx_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det_i) begin
        state_q   <= LNK_RX;
        stage_q   <= STG_ADDR;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (stop_det_i) begin
        state_q <= LNK_IDLE;
        ack_q   <= 1'b0;
      end else begin
        unique case (state_q)
          LNK_RX: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (byte_done) begin
              if (byte_ok) begin
                ack_q   <= 1'b1;
                state_q <= LNK_ACK;
                if (stage_q == STG_CNT) begin
                  remain_q <= shreg_q[IDX_W-1:0];
                  idx_q    <= '0;
                end
                if (stage_q == STG_DATA) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= idx_q;
                  wr_data_o <= shreg_q;
                  remain_q  <= remain_q - 1'b1;
                  idx_q     <= idx_q + 1'b1;
                end
              end else begin
                state_q <= LNK_IDLE;
              end
            end
          end
          LNK_ACK: begin
            if (scl_fall_i) begin
              ack_q     <= 1'b0;
              state_q   <= LNK_RX;
              bit_cnt_q <= '0;
              if (stage_q != STG_DATA) stage_q <= stage_e'(stage_q + 2'd1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_o = ack_q;

  p_ack_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(scl_fall_i));
  p_ack_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> $past(scl_fall_i || stop_det_i || start_det_i));
  p_stop_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det_i && !start_det_i) |=> (!ack_q && state_q == LNK_IDLE));
  p_bitcnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LNK_RX) |-> (bit_cnt_q <= 4'd8));
  p_wr_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (int'(wr_idx_o) < MAX_CNT));
endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
  import smb_cfg_pkg::*;
#(
  parameter int NREG = 6,
  parameter int IDX_W = 6,
  parameter int SS_REG = 0,
  parameter int SS_BIT = 3,
  parameter int MODE_REG = 5,
  parameter int MODE_A_BIT = 5,
  parameter int MODE_B_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [7:0]        wr_data_i,
  output logic [NREG*8-1:0] cfg_o,
  output logic              ss_en_o,
  output logic              spread_deep_o,
  output logic [1:0]        oclk_lvl_o,
  output logic              tristate_req_o
);
  logic [NREG-1:0][7:0] regs_q;
  logic ss, ma, mb;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g)) regs_q[g] <= wr_data_i;
    end
    assign cfg_o[g*8 +: 8] = regs_q[g];
  end

  assign ss = regs_q[SS_REG][SS_BIT];
  assign ma = regs_q[MODE_REG][MODE_A_BIT];
  assign mb = regs_q[MODE_REG][MODE_B_BIT];

  always_comb begin
    if (ss)            oclk_lvl_o = ma ? OC_5PCT : OC_NONE;
    else if (ma && !mb) oclk_lvl_o = OC_5PCT;
    else if (!ma && mb) oclk_lvl_o = OC_10PCT;
    else               oclk_lvl_o = OC_NONE;
  end

  assign ss_en_o        = ss;
  assign spread_deep_o  = ss & mb;
  assign tristate_req_o = ~ss & ma & mb;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o));
  p_oc10_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oclk_lvl_o == OC_10PCT) |-> !ss_en_o);
  p_tri_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tristate_req_o |-> (!ss_en_o && oclk_lvl_o == OC_NONE && !spread_deep_o));
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter logic [7:0] CMD_CODE = 8'h00,
  parameter int NREG = 6,
  parameter int MAX_CNT = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [NREG*8-1:0] cfg_o,
  output logic              ss_en_o,
  output logic              spread_deep_o,
  output logic [1:0]        oclk_lvl_o,
  output logic              tristate_req_o
);
  localparam int IDX_W = $clog2(MAX_CNT + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_link_fsm #(
    .SLV_ADDR(SLV_ADDR), .CMD_CODE(CMD_CODE), .MAX_CNT(MAX_CNT), .IDX_W(IDX_W)
  ) u_link (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_det_i(start_det), .stop_det_i(stop_det), .ack_o(sda_pull_o),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  smb_cfg_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .cfg_o, .ss_en_o, .spread_deep_o, .oclk_lvl_o, .tristate_req_o
  );
endmodule

// File: tb/cfg_smbus_slave_bench.sv
module cfg_smbus_slave_bench;
  localparam int Q = 4;
  localparam int NV = 10;

  typedef struct packed {
    logic [7:0]  addr;
    logic [7:0]  cmd;
    logic [7:0]  cnt;
    logic [3:0]  nsend;
    logic [63:0] data;
    logic [47:0] exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'hD2, 8'h00, 8'd3,  4'd3, 64'h0000_0000_0033_2211, 48'h0000_0033_2211},
    '{8'hD4, 8'h00, 8'd3,  4'd3, 64'h0000_0000_00AA_AAAA, 48'h0000_0033_2211},
    '{8'hD2, 8'h01, 8'd3,  4'd3, 64'h0000_0000_0099_9999, 48'h0000_0033_2211},
    '{8'hD2, 8'h00, 8'd0,  4'd1, 64'h0000_0000_0000_0077, 48'h0000_0033_2211},
    '{8'hD2, 8'h00, 8'h21, 4'd1, 64'h0000_0000_0000_0077, 48'h0000_0033_2211},
    '{8'hD2, 8'h00, 8'd6,  4'd6, 64'h0000_60C3_3CA5_5A08, 48'h60C3_3CA5_5A08},
    '{8'hD2, 8'h00, 8'd8,  4'd8, 64'h8877_0605_0403_0201, 48'h0605_0403_0201},
    '{8'hD2, 8'h00, 8'd2,  4'd4, 64'h0000_0000_5555_0FF0, 48'h0605_0403_0FF0},
    '{8'hD3, 8'h00, 8'd2,  4'd2, 64'h0000_0000_0000_0101, 48'h0605_0403_0FF0},
    '{8'hD2, 8'h00, 8'd32, 4'd2, 64'h0000_0000_0000_0000, 48'h0605_0403_0000}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, ss_en, spread_deep, tri_req;
  logic [1:0] oclk_lvl;
  logic [47:0] cfg;
  logic sda_bus;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  assign sda_bus = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  cfg_smbus_slave u_cfg_smbus_slave (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .cfg_o(cfg), .ss_en_o(ss_en),
    .spread_deep_o(spread_deep), .oclk_lvl_o(oclk_lvl), .tristate_req_o(tri_req)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    acked = ~sda_bus;
    wq(Q);
    scl_m = 1'b0; wq(Q);
    if (acked) chk(sda_pull == 1'b0, "R11 ack release", 64'(sda_pull), 64'd0);
  endtask

  task automatic run_txn(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                         input int nsend, input logic [63:0] data);
    logic a;
    bit e_addr, e_cmd, e_cnt;
    e_addr = (addr == 8'hD2);
    e_cmd  = e_addr && (cmd == 8'h00);
    e_cnt  = e_cmd && (cnt != 8'd0) && (cnt <= 8'd32);
    bus_start();
    send_byte(addr, a);
    chk(a == e_addr, "R2 address ack", 64'(a), 64'(e_addr));
    send_byte(cmd, a);
    chk(a == e_cmd, "R3 command ack", 64'(a), 64'(e_cmd));
    send_byte(cnt, a);
    chk(a == e_cnt, "R4 count ack", 64'(a), 64'(e_cnt));
    for (int i = 0; i < nsend; i++) begin
      bit e_d;
      e_d = e_cnt && (i < int'(cnt));
      send_byte(data[8*i +: 8], a);
      chk(a == e_d, (i >= 6) ? "R6 data ack" : "R5 data ack", 64'(a), 64'(e_d));
    end
    bus_stop();
    wq(4);
  endtask

  task automatic write_mode(input logic [7:0] r0, input logic [7:0] r5);
    run_txn(8'hD2, 8'h00, 8'd6, 6, {16'h0, r5, 32'h0, r0});
  endtask

  task automatic chk_mode(input string req, input logic e_ss, input logic e_deep,
                          input logic [1:0] e_oc, input logic e_tri);
    chk({ss_en, spread_deep, oclk_lvl, tri_req} == {e_ss, e_deep, e_oc, e_tri}, req,
        64'({ss_en, spread_deep, oclk_lvl, tri_req}), 64'({e_ss, e_deep, e_oc, e_tri}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic a;
    wq(5);
    // R1 reset state
    chk(cfg == 48'h0, "R1 regs", 64'(cfg), 64'h0);
    chk(sda_pull == 1'b0, "R1 sda released", 64'(sda_pull), 64'h0);
    chk_mode("R1 decoded outputs", 1'b0, 1'b0, 2'd0, 1'b0);
    rst_ni = 1'b1;
    wq(4);

    for (int v = 0; v < NV; v++) begin
      run_txn(VECS[v].addr, VECS[v].cmd, VECS[v].cnt, int'(VECS[v].nsend), VECS[v].data);
      chk(cfg == VECS[v].exp, "R2/R3/R4/R5/R6 register bank", 64'(cfg), 64'(VECS[v].exp));
    end

    // R7: STOP in the middle of a byte
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'd3, a);
    send_byte(8'h5C, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    wq(4);
    chk(cfg == 48'h0605_0403_005C, "R7 stop abort", 64'(cfg), 64'h0605_0403_005C);

    // R7: repeated START in the middle of a byte
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'd3, a);
    send_byte(8'h11, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'd1, a);
    send_byte(8'h22, a);
    chk(a == 1'b1, "R7 restart transaction ack", 64'(a), 64'd1);
    bus_stop();
    wq(4);
    chk(cfg == 48'h0605_0403_0022, "R7 restart abort", 64'(cfg), 64'h0605_0403_0022);

    // R8/R9/R10 mode decode, spread on
    write_mode(8'h08, 8'h00); chk_mode("R8 R9 ss on 00", 1'b1, 1'b0, 2'd0, 1'b0);
    write_mode(8'h08, 8'h40); chk_mode("R9 ss on deep", 1'b1, 1'b1, 2'd0, 1'b0);
    write_mode(8'h08, 8'h20); chk_mode("R9 ss on 5pct", 1'b1, 1'b0, 2'd1, 1'b0);
    write_mode(8'h08, 8'h60); chk_mode("R9 R10 ss on both", 1'b1, 1'b1, 2'd1, 1'b0);
    // spread off
    write_mode(8'hF7, 8'h00); chk_mode("R8 R9 ss off 00", 1'b0, 1'b0, 2'd0, 1'b0);
    write_mode(8'h00, 8'h40); chk_mode("R9 ss off 10pct", 1'b0, 1'b0, 2'd2, 1'b0);
    write_mode(8'h00, 8'h20); chk_mode("R9 ss off 5pct", 1'b0, 1'b0, 2'd1, 1'b0);
    write_mode(8'h00, 8'h60); chk_mode("R10 tristate request", 1'b0, 1'b0, 2'd0, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule